// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a binary search for an analog-to-digital converter. It drives a trial code into an external binary-weighted DAC. It reads back a single comparator decision for each trial and builds the converted code one bit at a time. The search starts at the most significant bit and ends at the least significant bit. When the last bit is settled, the code is written to a result register in the selected output coding, and only then does the busy flag drop.

A conversion is requested by pulling the active-low convert input low while the controller is idle and armed. The controller arms when it sees the convert input high during an idle cycle. Requests made during a conversion are ignored. Each conversion produces only its own result, so the analog source may be switched between any two conversions.

The result is a plain held register. It has no valid/ready handshake and no back-pressure: a reader samples it whenever busy is low, and it keeps its value until the next conversion loads a new one. The convert, comparator and coding pins are plain control and status pins.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) forces busy to 0, trial to all zeros and result to all zeros.
- R2: When the controller is idle and armed, and conv_n is low at a rising edge, a conversion begins. After that edge busy is 1 and trial holds only its top bit set (0x8000 when WIDTH is 16).
- R3: Bits are tested from the top down, one per clock. After the k-th edge of the conversion (k = 1 for the start edge, up to WIDTH), trial equals the bits already decided, then a 1 at position WIDTH-k, then zeros below it.
- R4: cmp_hi = 1 means the analog input is at or above the current trial, and the tested bit is kept. cmp_hi = 0 clears the tested bit. The final code is the largest code that is not above the input.
- R5: busy stays high for exactly WIDTH+1 rising edges: WIDTH bit decisions, then one load cycle. It falls on the same edge that loads result.
- R6: twos_sel is sampled on the load edge. With twos_sel = 0, result is the straight binary code. With twos_sel = 1, result is that code with its top bit inverted (two's complement, so midscale gives 0x0000 at 16 bits).
- R7: An input above the top code gives an all-ones straight binary code. An input below zero gives all zeros.
- R8: A conv_n low level or low pulse while busy is ignored. A new conversion needs conv_n to be seen high on an idle cycle and then low.
- R9: result changes only on the load edge. Between loads it holds its value, whatever twos_sel, conv_n or cmp_hi do.
- R10: Each result depends only on the comparator decisions of its own conversion. Back-to-back conversions show no carry-over from the previous code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_n | input | 1 | Convert request, active low, level sampled |
| cmp_hi | input | 1 | Comparator decision: 1 when input is at or above trial |
| twos_sel | input | 1 | Output coding: 0 straight binary, 1 two's complement |
| trial | output | WIDTH | Trial code driven to the binary-weighted DAC |
| busy | output | 1 | High from start edge until result is loaded |
| result | output | WIDTH | Last completed conversion code |

## Verification
The bench builds the controller with WIDTH set to 8. This makes it possible to convert every code from zero to full scale, plus inputs a few steps beyond each end, in both output codings. Checking trial after every bit cycle covers each bit position being kept and cleared, and the exact length of the busy window. The same small setup also allows targeted runs with convert pulses during busy and coding changes while idle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEST = 2'd1,
    ST_LOAD = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_n,
  input  logic idle,
  output logic go
);
  logic armed_q;

  assign go = idle && armed_q && !conv_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (go) begin
      armed_q <= 1'b0;
    end else if (idle && conv_n) begin
      armed_q <= 1'b1;
    end
  end

  // a start can only follow an idle cycle with conv_n seen high
  AST_GO_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(conv_n) || $past(!idle)); // R8
endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial,
  output logic             idle,
  output logic             load
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       state_q;
  logic [WIDTH-1:0] trial_q;
  logic [WIDTH-1:0] probe_q;
  logic [WIDTH-1:0] trial_nx;

  always_comb begin
    trial_nx = trial_q;
    if (!cmp_hi) trial_nx = trial_nx & ~probe_q;
    if (!probe_q[0]) trial_nx = trial_nx | (probe_q >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trial_q <= '0;
      probe_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q <= ST_TEST;
            trial_q <= TOP_BIT;
            probe_q <= TOP_BIT;
          end
        end
        ST_TEST: begin
          trial_q <= trial_nx;
          if (probe_q[0]) state_q <= ST_LOAD;
          else            probe_q <= probe_q >> 1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign trial = trial_q;
  assign idle  = (state_q == ST_IDLE);
  assign load  = (state_q == ST_LOAD);

  AST_PROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TEST) |-> $onehot(probe_q) && ((trial_q & (probe_q - 1'b1)) == '0)); // R3
  AST_KEEP_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TEST && cmp_hi) |=> ((trial_q & $past(probe_q)) != '0)); // R4
  AST_CLEAR_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TEST && !cmp_hi) |=> ((trial_q & $past(probe_q)) == '0)); // R4
endmodule

// File: rtl/sar_coder.sv
module sar_coder #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             twos_sel,
  input  logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] result_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    result_q <= '0;
    else if (load) result_q <= {code[WIDTH-1] ^ twos_sel, code[WIDTH-2:0]};
  end

  assign result = result_q;

  AST_LOW_BITS_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (result_q[WIDTH-2:0] == $past(code[WIDTH-2:0]))); // R6
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_n,
  input  logic             cmp_hi,
  input  logic             twos_sel,
  output logic [WIDTH-1:0] trial,
  output logic             busy,
  output logic [WIDTH-1:0] result
);
  localparam int CW = $clog2(WIDTH + 2);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic          go;
  logic          idle;
  logic          load;
  logic [CW-1:0] span_q;

  sar_start_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .conv_n (conv_n),
    .idle   (idle),
    .go     (go)
  );

  sar_search #(.WIDTH(WIDTH)) u_search (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .cmp_hi (cmp_hi),
    .trial  (trial),
    .idle   (idle),
    .load   (load)
  );

  sar_coder #(.WIDTH(WIDTH)) u_coder (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .twos_sel (twos_sel),
    .code     (trial),
    .result   (result)
  );

  assign busy = !idle;

  always_ff @(posedge clk) begin
    if (!rst_n)    span_q <= '0;
    else if (busy) span_q <= span_q + 1'b1;
    else           span_q <= '0;
  end

  AST_START_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (trial == TOP_BIT) && $past(!conv_n)); // R2
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (span_q == CW'(WIDTH + 1))); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(result)); // R9
endmodule

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;
  localparam int W = 8;
  localparam int FS = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv_n = 1'b1;
  logic         cmp_hi;
  logic         twos_sel = 1'b0;
  logic [W-1:0] trial;
  logic         busy;
  logic [W-1:0] result;

  int vin = 0;
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  // ideal comparator against the bench's digital input value
  assign cmp_hi = (vin >= int'(trial));

  sar_conv_ctrl #(.WIDTH(W)) u_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cmp_hi(cmp_hi),
    .twos_sel(twos_sel), .trial(trial), .busy(busy), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v < 0) return 0;
    if (v > FS - 1) return FS - 1;
    return v;
  endfunction

  // noise: 1 drops conv_n during busy (R8) and holds it low afterwards
  task automatic convert(input int v, input bit tw, input bit noise);
    int code;
    int expt;
    int held;
    code = sat(v);
    vin = v;
    twos_sel = tw;
    @(negedge clk) conv_n = 1'b1;
    @(negedge clk) conv_n = 1'b0;
    @(negedge clk) conv_n = 1'b1;
    for (int k = 1; k <= W; k++) begin
      expt = ((code >> (W - k + 1)) << (W - k + 1)) | (1 << (W - k));
      if (k == 1) chk(int'(trial) == expt, "R2 start trial", int'(trial), expt);
      else        chk(int'(trial) == expt, "R3 step trial", int'(trial), expt);
      chk(busy == 1'b1, "R5 busy during search", int'(busy), 1);
      if (noise && k == 2) conv_n = 1'b0;
      if (noise && k == 4) conv_n = 1'b1;
      if (noise && k == 5) conv_n = 1'b0;
      @(negedge clk);
    end
    chk(int'(trial) == code, "R4 final code", int'(trial), code);
    chk(busy == 1'b1, "R5 busy in load cycle", int'(busy), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R5 busy falls", int'(busy), 0);
    expt = tw ? (code ^ (1 << (W - 1))) : code;
    if (v < 0 || v > FS - 1)
      chk(int'(result) == expt, "R7 saturated result", int'(result), expt);
    else
      chk(int'(result) == expt, "R6 R10 coded result", int'(result), expt);
    if (noise) begin
      held = int'(result);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(busy == 1'b0, "R8 held low no restart", int'(busy), 0);
        chk(int'(result) == held, "R8 result unchanged", int'(result), held);
      end
      conv_n = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(trial == '0, "R1 reset trial", int'(trial), 0);
    chk(result == '0, "R1 reset result", int'(result), 0);
    rst_n = 1'b1;

    // R4 R6 R7 R10: every code plus out-of-range inputs, both codings
    for (int tw = 0; tw < 2; tw++)
      for (int v = -3; v <= FS + 2; v++)
        convert(v, tw[0], 1'b0);

    // R10: alternate extremes back to back
    convert(FS - 1, 1'b0, 1'b0);
    convert(0, 1'b0, 1'b0);
    convert(FS / 2, 1'b1, 1'b0);

    // R8: convert requests during busy are ignored
    convert(FS / 3, 1'b0, 1'b1);
    convert(FS / 5, 1'b1, 1'b1);

    // R9: coding and comparator changes while idle leave result alone
    convert(FS / 2 + 1, 1'b0, 1'b0);
    held = int'(result);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      twos_sel = ~twos_sel;
      vin = (i % 2 == 0) ? -1 : FS;
      @(negedge clk);
      chk(int'(result) == held, "R9 result held while idle", int'(result), held);
      chk(busy == 1'b0, "R9 no start with conv_n high", int'(busy), 0);
    end

    // R1: reset in mid conversion returns to idle and clears result
    vin = FS - 1;
    @(negedge clk) conv_n = 1'b0;
    @(negedge clk) conv_n = 1'b1;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    chk(busy == 1'b0, "R1 mid reset busy", int'(busy), 0);
    chk(result == '0, "R1 mid reset result", int'(result), 0);
    chk(trial == '0, "R1 mid reset trial", int'(trial), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule